// File: doc/BRIEF.md
# Flash Controller Host FIFO Pair

This block is the data buffering between a flash controller's engines and its register bus. It has two 32-bit FIFOs of 16 entries each. The read FIFO is filled by the flash read engine and drained by bus reads of a data register. The program FIFO is filled by bus writes to a data register and drained by the program engine.

Software sees the full and empty flags of both FIFOs and the fill count of each. It can program two watermark thresholds, and it can hold both FIFOs empty through a reset control bit. Four interrupt state bits follow the FIFO occupancy. The read-level bit fires when the read FIFO has filled to its threshold. The program-level bit fires when the program FIFO has drained to its threshold. The other two bits report read-FIFO full and program-FIFO empty.

Registers are reached through a single-cycle strobe interface. A read strobe captures the addressed value into `reg_rdata_o` at the clock edge. A write strobe takes effect at the same edge. Register offsets on `reg_addr_i`: 0 status, 1 watermark, 2 current level, 3 FIFO reset, 4 read data, 5 program data.

Top module: `flash_host_fifos`

## Requirements
- R1: Each FIFO holds 16 words. The status register (offset 0) reads the live flags of both FIFOs: bit0 read-full, bit1 read-empty, bit2 program-full, bit3 program-empty. After reset it reads 0x0000000A.
- R2: `intr_o[0]` is 1 while the read FIFO count is greater than or equal to the read threshold, and 0 otherwise.
- R3: `intr_o[1]` is 1 while the program FIFO count is less than or equal to the program threshold, and 0 otherwise.
- R4: A write to the watermark register (offset 1) stores bits [4:0] as the program threshold and bits [12:8] as the read threshold. All other bits are dropped and read back as 0. Both level interrupts use the new thresholds from the next cycle. Both thresholds reset to 0.
- R5: Writing offset 3 stores bit0 as the FIFO-reset control. A write with bit0=1 empties both FIFOs at that edge, and this takes priority over any push or pop in the same cycle. While the control reads 1, pushes into either FIFO are discarded.
- R6: A bus write to offset 5 pushes the word into the program FIFO when the FIFO is not full and the reset control is 0. A write to a full program FIFO is dropped, and `reg_err_o` is 1 for exactly the following cycle.
- R7: A bus read of offset 4 returns the oldest read-FIFO word and removes it. A read of an empty read FIFO returns 0 and changes nothing.
- R8: The current-level register (offset 2) reads the program FIFO count in bits [4:0] and the read FIFO count in bits [12:8]. All other bits read 0.
- R9: `intr_o[2]` equals read-FIFO full. `intr_o[3]` equals program-FIFO empty. So reset and FIFO reset give `intr_o[3]=1` and `intr_o[2]=0`, and a program push clears `intr_o[3]`.
- R10: `pg_pop_i` removes the oldest program word, which is shown on `pg_rdata_o` whenever `pg_empty_o` is 0. A pop while the FIFO is empty is ignored.
- R11: `rd_push_i` appends `rd_wdata_i` to the read FIFO unless the FIFO is full (`rd_full_o`=1) or the reset control is 1, in which case the word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, valid the cycle after the read strobe |
| reg_err_o | output | 1 | One-cycle pulse after a dropped program write |
| rd_push_i | input | 1 | Read engine push |
| rd_wdata_i | input | 32 | Read engine word |
| rd_full_o | output | 1 | Read FIFO full |
| pg_pop_i | input | 1 | Program engine pop |
| pg_rdata_o | output | 32 | Oldest program FIFO word |
| pg_empty_o | output | 1 | Program FIFO empty |
| intr_o | output | 4 | Interrupt state: read level, program level, read full, program empty |

## Verification
Every flag, level and interrupt is derived from the two occupancy counters. A count that is off by one therefore shows up on the next cycle as a wrong level-register value or a wrong watermark bit. Full and empty slip only at the ends of the range. Pointer or storage faults show up as a wrong word: on `pg_rdata_o` in the same cycle, or on `reg_rdata_o` after the next data read. The bench mixes random traffic on both FIFOs with random thresholds and occasional FIFO resets. After every edge it compares every output and every register read against a queue model.

// File: rtl/hf_pkg.sv
package hf_pkg;
  localparam int unsigned DW    = 32;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned CW    = $clog2(DEPTH + 1);
  localparam int unsigned PG_LSB = 0;
  localparam int unsigned RD_LSB = 8;

  localparam logic [2:0] A_STATUS = 3'd0;
  localparam logic [2:0] A_WMARK  = 3'd1;
  localparam logic [2:0] A_LEVEL  = 3'd2;
  localparam logic [2:0] A_FRST   = 3'd3;
  localparam logic [2:0] A_RDATA  = 3'd4;
  localparam logic [2:0] A_PDATA  = 3'd5;
endpackage

// File: rtl/hf_fifo.sv
module hf_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] head_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;
  logic          do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && !empty_o && !clr_i;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      if (do_push && !do_pop)      count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH)); // R1
  AST_FULL_PUSH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !clr_i |=> full_o); // R1
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i && !clr_i |=> empty_o); // R10
  AST_CLR_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o); // R5
endmodule

// File: rtl/hf_lvl.sv
module hf_lvl #(
  parameter int unsigned CW   = 5,
  parameter bit          FILL = 1'b1
) (
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] thr_i,
  output logic          hit_o
);
  generate
    if (FILL) begin : g_fill
      assign hit_o = (count_i >= thr_i);
    end else begin : g_drain
      assign hit_o = (count_i <= thr_i);
    end
  endgenerate
endmodule

// File: rtl/flash_host_fifos.sv
module flash_host_fifos
  import hf_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          reg_err_o,
  input  logic          rd_push_i,
  input  logic [DW-1:0] rd_wdata_i,
  output logic          rd_full_o,
  input  logic          pg_pop_i,
  output logic [DW-1:0] pg_rdata_o,
  output logic          pg_empty_o,
  output logic [3:0]    intr_o
);
  logic [CW-1:0] rd_cnt, pg_cnt, wm_rd_q, wm_pg_q;
  logic [DW-1:0] rd_head, rdata_q, rd_mux;
  logic          rd_full, rd_empty, pg_full, pg_empty;
  logic          frst_q, err_q, clr;
  logic          wr_pdata, rd_rdata, rd_lvl, pg_lvl;

  assign clr      = reg_we_i && (reg_addr_i == A_FRST) && reg_wdata_i[0];
  assign wr_pdata = reg_we_i && (reg_addr_i == A_PDATA);
  assign rd_rdata = reg_re_i && (reg_addr_i == A_RDATA);

  hf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rd (
    .clk_i, .rst_ni, .clr_i(clr),
    .push_i(rd_push_i && !frst_q), .wdata_i(rd_wdata_i),
    .pop_i(rd_rdata), .head_o(rd_head), .count_o(rd_cnt),
    .full_o(rd_full), .empty_o(rd_empty)
  );

  hf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_pg (
    .clk_i, .rst_ni, .clr_i(clr),
    .push_i(wr_pdata && !frst_q), .wdata_i(reg_wdata_i),
    .pop_i(pg_pop_i), .head_o(pg_rdata_o), .count_o(pg_cnt),
    .full_o(pg_full), .empty_o(pg_empty)
  );

  hf_lvl #(.CW(CW), .FILL(1'b1)) u_rd_lvl (.count_i(rd_cnt), .thr_i(wm_rd_q), .hit_o(rd_lvl));
  hf_lvl #(.CW(CW), .FILL(1'b0)) u_pg_lvl (.count_i(pg_cnt), .thr_i(wm_pg_q), .hit_o(pg_lvl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wm_rd_q <= '0;
      wm_pg_q <= '0;
      frst_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= wr_pdata && pg_full;
      if (reg_we_i && reg_addr_i == A_WMARK) begin
        wm_pg_q <= reg_wdata_i[PG_LSB +: CW];
        wm_rd_q <= reg_wdata_i[RD_LSB +: CW];
      end
      if (reg_we_i && reg_addr_i == A_FRST) frst_q <= reg_wdata_i[0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr_i)
      A_STATUS: rd_mux[3:0] = {pg_empty, pg_full, rd_empty, rd_full};
      A_WMARK: begin
        rd_mux[PG_LSB +: CW] = wm_pg_q;
        rd_mux[RD_LSB +: CW] = wm_rd_q;
      end
      A_LEVEL: begin
        rd_mux[PG_LSB +: CW] = pg_cnt;
        rd_mux[RD_LSB +: CW] = rd_cnt;
      end
      A_FRST:  rd_mux[0] = frst_q;
      A_RDATA: rd_mux = rd_empty ? '0 : rd_head;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign reg_err_o   = err_q;
  assign rd_full_o   = rd_full;
  assign pg_empty_o  = pg_empty;
  assign intr_o      = {pg_empty, rd_full, pg_lvl, rd_lvl};

  AST_FRST_HOLDS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frst_q |-> (rd_cnt == '0) && (pg_cnt == '0)); // R5
  AST_FULL_WRITE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pdata && pg_full |=> reg_err_o && !pg_empty_o); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_err_o |-> $past(wr_pdata)); // R6
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rdata && rd_empty |=> reg_rdata_o == '0); // R7
  AST_PUSH_CLEARS_PG_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pdata && !frst_q && !clr && !pg_pop_i |=> !intr_o[3]); // R9
endmodule

// File: tb/sim_flash_host_fifos.sv
`timescale 1ns/1ps
module sim_flash_host_fifos;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we, re, rdp, pgp;
  logic [2:0]  addr;
  logic [31:0] wd, rdw;
  logic [31:0] rdata, pg_rdata;
  logic        err, rd_full, pg_empty;
  logic [3:0]  intr;

  int unsigned n_chk = 0, n_err = 0;
  logic [31:0] rq[$], pq[$];
  logic [4:0]  m_wrd, m_wpg;
  logic        m_rst;

  always #2 clk = ~clk;

  flash_host_fifos u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wd), .reg_rdata_o(rdata), .reg_err_o(err), .rd_push_i(rdp),
    .rd_wdata_i(rdw), .rd_full_o(rd_full), .pg_pop_i(pgp), .pg_rdata_o(pg_rdata),
    .pg_empty_o(pg_empty), .intr_o(intr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_reg(input logic [2:0] a);
    logic [31:0] v = '0;
    case (a)
      3'd0: v[3:0] = {pq.size() == 0, pq.size() == 16, rq.size() == 0, rq.size() == 16};
      3'd1: begin v[4:0] = m_wpg; v[12:8] = m_wrd; end
      3'd2: begin v[4:0] = 5'(pq.size()); v[12:8] = 5'(rq.size()); end
      3'd3: v[0] = m_rst;
      3'd4: v = (rq.size() == 0) ? '0 : rq[0];
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic logic [3:0] exp_intr();
    return {pq.size() == 0, rq.size() == 16,
            5'(pq.size()) <= m_wpg, 5'(rq.size()) >= m_wrd};
  endfunction

  function automatic string req_of(input logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd1: return "R4";
      3'd2: return "R8";
      3'd3: return "R5";
      3'd4: return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic cyc(input bit i_rdp, input logic [31:0] i_rdw, input bit i_pgp,
                     input bit i_we, input bit i_re, input logic [2:0] i_a, input logic [31:0] i_wd);
    logic [31:0] e_rd;
    bit e_err, clr, rd_pre_full, rd_pre_empty, pg_pre_full, pg_pre_empty;
    rdp = i_rdp; rdw = i_rdw; pgp = i_pgp; we = i_we; re = i_re; addr = i_a; wd = i_wd;
    e_rd = exp_reg(i_a);
    rd_pre_full = rq.size() == 16; rd_pre_empty = rq.size() == 0;
    pg_pre_full = pq.size() == 16; pg_pre_empty = pq.size() == 0;
    e_err = i_we && i_a == 3'd5 && pg_pre_full;
    clr = i_we && i_a == 3'd3 && i_wd[0];
    if (clr) begin
      rq.delete(); pq.delete();
    end else begin
      if (i_re && i_a == 3'd4 && !rd_pre_empty) void'(rq.pop_front());
      if (i_rdp && !m_rst && !rd_pre_full) rq.push_back(i_rdw);
      if (i_pgp && !pg_pre_empty) void'(pq.pop_front());
      if (i_we && i_a == 3'd5 && !m_rst && !pg_pre_full) pq.push_back(i_wd);
    end
    if (i_we && i_a == 3'd1) begin m_wpg = i_wd[4:0]; m_wrd = i_wd[12:8]; end
    if (i_we && i_a == 3'd3) m_rst = i_wd[0];
    @(posedge clk);
    @(negedge clk);
    rdp = 0; pgp = 0; we = 0; re = 0;
    if (i_re) chk(rdata == e_rd, req_of(i_a), rdata, e_rd);
    chk(err == e_err, "R6 err", {31'b0, err}, {31'b0, e_err});
    chk(intr == exp_intr(), "R2 R3 R9 intr", {28'b0, intr}, {28'b0, exp_intr()});
    chk(rd_full == (rq.size() == 16), "R11 rd_full", {31'b0, rd_full}, {31'b0, rq.size() == 16});
    chk(pg_empty == (pq.size() == 0), "R10 pg_empty", {31'b0, pg_empty}, {31'b0, pq.size() == 0});
    if (pq.size() != 0) chk(pg_rdata == pq[0], "R10 pg_rdata", pg_rdata, pq[0]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 0; we = 0; re = 0; rdp = 0; pgp = 0; addr = 0; wd = 0; rdw = 0;
    m_wrd = 0; m_wpg = 0; m_rst = 0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    chk(intr == 4'b1011, "R9 reset intr", {28'b0, intr}, 32'hB);
    chk(!rd_full && pg_empty && !err, "R1 reset flags", {29'b0, rd_full, pg_empty, err}, 32'h2);
    cyc(0, 0, 0, 0, 1, 3'd0, 0); // R1 status reset value 0xA
    chk(rdata == 32'hA, "R1 reset status", rdata, 32'hA);
    // fill program FIFO, overfill
    for (int i = 0; i < 18; i++) cyc(0, 0, 0, 1, 0, 3'd5, 32'hA000_0000 + i);
    cyc(0, 0, 0, 0, 1, 3'd2, 0); // R8
    // fill read FIFO, overfill; R11
    for (int i = 0; i < 18; i++) cyc(1, 32'h5000_0000 + i, 0, 0, 0, 3'd0, 0);
    cyc(0, 0, 0, 0, 1, 3'd0, 0);
    // thresholds with stray bits; R4
    cyc(0, 0, 0, 1, 0, 3'd1, 32'hFFFF_E30C);
    cyc(0, 0, 0, 0, 1, 3'd1, 0);
    // drain read FIFO past empty; R7
    for (int i = 0; i < 18; i++) cyc(0, 0, 0, 0, 1, 3'd4, 0);
    // drain program FIFO past empty; R10
    for (int i = 0; i < 18; i++) cyc(0, 0, 1, 0, 0, 3'd0, 0);
    // FIFO reset: refill some, reset, pushes discarded; R5
    for (int i = 0; i < 5; i++) cyc(1, 32'h77 + i, 0, 1, 0, 3'd5, 32'h99 + i);
    cyc(1, 32'h1, 0, 1, 0, 3'd3, 32'h1);
    cyc(1, 32'h2, 0, 1, 0, 3'd5, 32'h3);
    cyc(0, 0, 0, 0, 1, 3'd2, 0);
    cyc(0, 0, 0, 0, 1, 3'd3, 0);
    cyc(0, 0, 0, 1, 0, 3'd3, 32'h0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int unsigned op = $urandom % 10;
      bit r_we = 0, r_re = 0;
      logic [2:0] a = 3'd0;
      logic [31:0] w = $urandom;
      case (op)
        2: begin r_re = 1; a = 3'd0; end
        3: begin r_re = 1; a = 3'd2; end
        4, 5: begin r_re = 1; a = 3'd4; end
        6, 7: begin r_we = 1; a = 3'd5; end
        8: begin r_we = 1; a = 3'd1; w = w & 32'h0000_1F1F; end
        9: begin r_we = 1; a = 3'd3; w = {31'b0, ($urandom % 6) == 0}; end
        default: ;
      endcase
      cyc(($urandom % 3) != 0, $urandom, ($urandom % 3) == 0, r_we, r_re, a, w);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule